// File: doc/BRIEF.md
# Isochronous Complete-Split State Updater

This block advances the transfer state of a split isochronous IN descriptor each time a complete-split attempt finishes. The descriptor fields are presented at its inputs: the remaining byte count, the 12-bit in-page offset, the page selector, the status bits and the complete-split progress mask. A single-cycle response strobe qualifies them together with the response token, the received payload length, the current micro-frame bit, a last-complete-split flag and an end-of-micro-frame flag. One cycle later the block presents the updated fields, a memory write enable for the payload, a retry request and a done pulse. The surrounding engine writes the fields back.

Transaction errors are retried at once. The descriptor has no field that counts these retries, so the block keeps its own counter and allows at most two. Data that would overrun the remaining byte count, or that exceeds the largest legal payload, is recorded as babble and is not written to memory.

Top module: `isoc_csplit_updater`

## Requirements
- R1: Out of reset every output is zero. `done` pulses exactly one cycle after each `rspValid` cycle. In cycles without a response `memWrEn` and `retryNow` are low and all field outputs hold their values.
- R2: On every response the output mask equals the input mask ORed with the micro-frame bit.
- R3: DATA0 (code 0) and DATA1 (code 1) with a length that fits subtract the length from the byte count. They add it to the offset modulo 4096. A carry past 4095 sets the page selector, which otherwise keeps its input value. Active is cleared, and `memWrEn` is raised when the length is not zero.
- R4: MDATA (code 2) advances the byte count, offset and page like R3 and raises `memWrEn` under the same rule, but Active keeps its input value.
- R5: A data response (codes 0 to 2) whose length exceeds the remaining byte count or 192 sets Babble and clears Active. It raises no `memWrEn` and leaves the byte count, offset and page at their input values.
- R6: ERR (code 4) sets the ERR bit and clears Active.
- R7: A transaction error (code 5) sets XactErr. If fewer than two retries have been used and `uframeEnd` is low, it raises `retryNow` and keeps Active. Otherwise it clears Active and does not raise `retryNow`.
- R8: The retry count returns to zero on `newDesc`, and `newDesc` takes effect on a response in the same cycle. It also returns to zero on any response other than a transaction error and when the retries are exhausted.
- R9: NYET (code 3) with `lastCs` high clears Active. NYET without `lastCs`, and the unused codes 6 and 7, change nothing but the mask. In both cases the byte count, offset, page and the other status bits keep their input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newDesc | input | 1 | A new descriptor starts; clears the retry count |
| rspValid | input | 1 | Single-cycle qualifier for all response and field inputs |
| rspKind | input | 3 | Response token code |
| rxLen | input | LEN_W (11) | Received payload length in bytes |
| lastCs | input | 1 | This complete-split is the last one scheduled |
| uframeEnd | input | 1 | The micro-frame is ending; no retry is possible |
| uframeBit | input | MASK_W (8) | One-hot bit of the current micro-frame |
| inBytes | input | BYTES_W (10) | Remaining byte count |
| inOffset | input | OFF_W (12) | Current in-page offset |
| inPage | input | 1 | Page selector |
| inActive | input | 1 | Active status bit |
| inErr | input | 1 | ERR status bit |
| inBabble | input | 1 | Babble status bit |
| inXact | input | 1 | XactErr status bit |
| inMask | input | MASK_W (8) | Complete-split progress mask |
| outBytes | output | BYTES_W (10) | Updated byte count |
| outOffset | output | OFF_W (12) | Updated offset |
| outPage | output | 1 | Updated page selector |
| outActive | output | 1 | Updated Active bit |
| outErr | output | 1 | Updated ERR bit |
| outBabble | output | 1 | Updated Babble bit |
| outXact | output | 1 | Updated XactErr bit |
| outMask | output | MASK_W (8) | Updated progress mask |
| memWrEn | output | 1 | Write the received payload to memory |
| retryNow | output | 1 | Reissue the complete-split immediately |
| done | output | 1 | Updated fields are valid this cycle |

## Verification
The bench uses the default parameters: a 10-bit byte count, an 11-bit length, a 12-bit offset, a 192-byte payload limit and two retries. Because the length is wider than the byte count, payloads past both the 192-byte limit and the remaining count can be driven. Offsets near 4095 make the page carry reachable with short lengths. A retry limit of two keeps runs of three back-to-back transaction errors common in random traffic, so exhaustion, clearing and same-cycle descriptor restarts all occur.

// File: rtl/isoc_csplit_pkg.sv
package isoc_csplit_pkg;

  localparam logic [2:0] RSP_DATA0 = 3'd0;
  localparam logic [2:0] RSP_DATA1 = 3'd1;
  localparam logic [2:0] RSP_MDATA = 3'd2;
  localparam logic [2:0] RSP_NYET  = 3'd3;
  localparam logic [2:0] RSP_ERR   = 3'd4;
  localparam logic [2:0] RSP_XERR  = 3'd5;

  // strobes from control to datapath for one committed response
  typedef struct packed {
    logic commit;
    logic advance;
    logic wrMem;
    logic setBabble;
    logic setErr;
    logic setXact;
    logic clrActive;
    logic retry;
  } ctlStrobe_t;

endpackage

// File: rtl/isoc_csplit_ctrl.sv
module isoc_csplit_ctrl
  import isoc_csplit_pkg::*;
#(
  parameter int MAX_RETRY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       newDesc,
  input  logic       rspValid,
  input  logic [2:0] rspKind,
  input  logic       lastCs,
  input  logic       uframeEnd,
  input  logic       overRun,
  input  logic       nonZeroLen,
  output ctlStrobe_t ctl
);

  localparam int CNT_W = $clog2(MAX_RETRY + 1);

  logic [CNT_W-1:0] retryCnt;
  logic [CNT_W-1:0] cntEff;
  logic [CNT_W-1:0] nextCnt;

  // a new descriptor clears the count before this cycle's response uses it
  assign cntEff = newDesc ? '0 : retryCnt;

  always_comb begin
    ctl     = '0;
    nextCnt = cntEff;
    if (rspValid) begin
      ctl.commit = 1'b1;
      nextCnt    = '0;
      case (rspKind)
        RSP_DATA0, RSP_DATA1, RSP_MDATA: begin
          if (overRun) begin
            ctl.setBabble = 1'b1;
            ctl.clrActive = 1'b1;
          end else begin
            ctl.advance   = 1'b1;
            ctl.wrMem     = nonZeroLen;
            ctl.clrActive = (rspKind != RSP_MDATA);
          end
        end
        RSP_ERR: begin
          ctl.setErr    = 1'b1;
          ctl.clrActive = 1'b1;
        end
        RSP_XERR: begin
          ctl.setXact = 1'b1;
          if ((int'(cntEff) < MAX_RETRY) && !uframeEnd) begin
            ctl.retry = 1'b1;
            nextCnt   = cntEff + 1'b1;
          end else begin
            ctl.clrActive = 1'b1;
          end
        end
        RSP_NYET: begin
          ctl.clrActive = lastCs;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) retryCnt <= '0;
    else       retryCnt <= nextCnt;
  end

  // R8
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(retryCnt) <= MAX_RETRY);

  // R7
  retry_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == RSP_XERR && !newDesc && int'(retryCnt) == MAX_RETRY) |-> !ctl.retry);

  // R5
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.advance, ctl.setBabble, ctl.setErr, ctl.setXact}));

endmodule

// File: rtl/isoc_csplit_dp.sv
module isoc_csplit_dp
  import isoc_csplit_pkg::*;
#(
  parameter int BYTES_W     = 10,
  parameter int OFF_W       = 12,
  parameter int LEN_W       = 11,
  parameter int MASK_W      = 8,
  parameter int MAX_PAYLOAD = 192
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [LEN_W-1:0]   rxLen,
  input  logic [MASK_W-1:0]  uframeBit,
  input  logic [BYTES_W-1:0] inBytes,
  input  logic [OFF_W-1:0]   inOffset,
  input  logic               inPage,
  input  logic               inActive,
  input  logic               inErr,
  input  logic               inBabble,
  input  logic               inXact,
  input  logic [MASK_W-1:0]  inMask,
  output logic               overRun,
  output logic               nonZeroLen,
  output logic [BYTES_W-1:0] outBytes,
  output logic [OFF_W-1:0]   outOffset,
  output logic               outPage,
  output logic               outActive,
  output logic               outErr,
  output logic               outBabble,
  output logic               outXact,
  output logic [MASK_W-1:0]  outMask,
  output logic               memWrEn,
  output logic               retryNow,
  output logic               done
);

  logic [OFF_W:0] offSum;

  assign overRun    = (int'(rxLen) > MAX_PAYLOAD) || (int'(rxLen) > int'(inBytes));
  assign nonZeroLen = (rxLen != '0);
  assign offSum     = {1'b0, inOffset} + (OFF_W+1)'(rxLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBytes  <= '0;
      outOffset <= '0;
      outPage   <= 1'b0;
      outActive <= 1'b0;
      outErr    <= 1'b0;
      outBabble <= 1'b0;
      outXact   <= 1'b0;
      outMask   <= '0;
      memWrEn   <= 1'b0;
      retryNow  <= 1'b0;
      done      <= 1'b0;
    end else begin
      memWrEn  <= ctl.wrMem;
      retryNow <= ctl.retry;
      done     <= ctl.commit;
      if (ctl.commit) begin
        outBytes  <= ctl.advance ? inBytes - BYTES_W'(rxLen) : inBytes;
        outOffset <= ctl.advance ? offSum[OFF_W-1:0] : inOffset;
        outPage   <= inPage | (ctl.advance & offSum[OFF_W]);
        outActive <= inActive & ~ctl.clrActive;
        outErr    <= inErr | ctl.setErr;
        outBabble <= inBabble | ctl.setBabble;
        outXact   <= inXact | ctl.setXact;
        outMask   <= inMask | uframeBit;
      end
    end
  end

  // R3
  write_shrinks_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (outBytes < $past(inBytes)));

  // R3
  page_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.commit && inPage) |=> outPage);

endmodule

// File: rtl/isoc_csplit_updater.sv
module isoc_csplit_updater
  import isoc_csplit_pkg::*;
#(
  parameter int BYTES_W     = 10,
  parameter int OFF_W       = 12,
  parameter int LEN_W       = 11,
  parameter int MASK_W      = 8,
  parameter int MAX_PAYLOAD = 192,
  parameter int MAX_RETRY   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               newDesc,
  input  logic               rspValid,
  input  logic [2:0]         rspKind,
  input  logic [LEN_W-1:0]   rxLen,
  input  logic               lastCs,
  input  logic               uframeEnd,
  input  logic [MASK_W-1:0]  uframeBit,
  input  logic [BYTES_W-1:0] inBytes,
  input  logic [OFF_W-1:0]   inOffset,
  input  logic               inPage,
  input  logic               inActive,
  input  logic               inErr,
  input  logic               inBabble,
  input  logic               inXact,
  input  logic [MASK_W-1:0]  inMask,
  output logic [BYTES_W-1:0] outBytes,
  output logic [OFF_W-1:0]   outOffset,
  output logic               outPage,
  output logic               outActive,
  output logic               outErr,
  output logic               outBabble,
  output logic               outXact,
  output logic [MASK_W-1:0]  outMask,
  output logic               memWrEn,
  output logic               retryNow,
  output logic               done
);

  ctlStrobe_t ctl;
  logic       overRun;
  logic       nonZeroLen;

  isoc_csplit_ctrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk(clk), .rstN(rstN), .newDesc(newDesc), .rspValid(rspValid),
    .rspKind(rspKind), .lastCs(lastCs), .uframeEnd(uframeEnd),
    .overRun(overRun), .nonZeroLen(nonZeroLen), .ctl(ctl)
  );

  isoc_csplit_dp #(
    .BYTES_W(BYTES_W), .OFF_W(OFF_W), .LEN_W(LEN_W),
    .MASK_W(MASK_W), .MAX_PAYLOAD(MAX_PAYLOAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxLen(rxLen), .uframeBit(uframeBit),
    .inBytes(inBytes), .inOffset(inOffset), .inPage(inPage), .inActive(inActive),
    .inErr(inErr), .inBabble(inBabble), .inXact(inXact), .inMask(inMask),
    .overRun(overRun), .nonZeroLen(nonZeroLen),
    .outBytes(outBytes), .outOffset(outOffset), .outPage(outPage),
    .outActive(outActive), .outErr(outErr), .outBabble(outBabble),
    .outXact(outXact), .outMask(outMask), .memWrEn(memWrEn),
    .retryNow(retryNow), .done(done)
  );

  // R1
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> done);

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (!memWrEn && !retryNow));

  // R2
  mask_keeps_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> ((outMask & $past(uframeBit)) == $past(uframeBit)));

  // R6
  err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == RSP_ERR) |=> (outErr && !outActive));

  // R9
  nyet_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == RSP_NYET) |=> (!memWrEn && !retryNow && outBytes == $past(inBytes)));

endmodule

// File: tb/isoc_csplit_updater_bench.sv
module isoc_csplit_updater_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        newDesc = 1'b0, rspValid = 1'b0, lastCs = 1'b0, uframeEnd = 1'b0;
  logic [2:0]  rspKind = '0;
  logic [10:0] rxLen = '0;
  logic [7:0]  uframeBit = '0, inMask = '0;
  logic [9:0]  inBytes = '0;
  logic [11:0] inOffset = '0;
  logic        inPage = 1'b0, inActive = 1'b0, inErr = 1'b0, inBabble = 1'b0, inXact = 1'b0;
  logic [9:0]  outBytes;
  logic [11:0] outOffset;
  logic [7:0]  outMask;
  logic        outPage, outActive, outErr, outBabble, outXact, memWrEn, retryNow, done;

  int total = 0;
  int bad = 0;
  int refCnt = 0;
  int eBytes = 0, eOff = 0, ePage = 0, eAct = 0, eErr = 0, eBab = 0, eX = 0, eMask = 0;
  int eWr = 0, eRetry = 0, eDone = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isoc_csplit_updater u_isoc_csplit_updater (
    .clk(clk), .rstN(rstN), .newDesc(newDesc), .rspValid(rspValid),
    .rspKind(rspKind), .rxLen(rxLen), .lastCs(lastCs), .uframeEnd(uframeEnd),
    .uframeBit(uframeBit), .inBytes(inBytes), .inOffset(inOffset),
    .inPage(inPage), .inActive(inActive), .inErr(inErr), .inBabble(inBabble),
    .inXact(inXact), .inMask(inMask), .outBytes(outBytes), .outOffset(outOffset),
    .outPage(outPage), .outActive(outActive), .outErr(outErr),
    .outBabble(outBabble), .outXact(outXact), .outMask(outMask),
    .memWrEn(memWrEn), .retryNow(retryNow), .done(done)
  );

  task automatic chk(string tag, string fld, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk("R1", "done", int'(done), eDone);
    chk("R2", "mask", int'(outMask), eMask);
    chk(tag, "bytes", int'(outBytes), eBytes);
    chk(tag, "offset", int'(outOffset), eOff);
    chk(tag, "page", int'(outPage), ePage);
    chk(tag, "active", int'(outActive), eAct);
    chk(tag, "err", int'(outErr), eErr);
    chk(tag, "babble", int'(outBabble), eBab);
    chk(tag, "xact", int'(outXact), eX);
    chk(tag, "memWrEn", int'(memWrEn), eWr);
    chk(tag, "retryNow", int'(retryNow), eRetry);
  endtask

  // reference model for one cycle, then compare after the clock edge
  task automatic cycle(string forceTag);
    int cnt;
    int len;
    int sum;
    string tag;
    cnt = newDesc ? 0 : refCnt;
    len = int'(rxLen);
    tag = "R1";
    eWr = 0;
    eRetry = 0;
    eDone = 0;
    if (rspValid) begin
      eDone = 1;
      eMask = int'(inMask | uframeBit);
      eBytes = int'(inBytes); eOff = int'(inOffset); ePage = int'(inPage);
      eAct = int'(inActive); eErr = int'(inErr); eBab = int'(inBabble); eX = int'(inXact);
      refCnt = 0;
      case (int'(rspKind))
        0, 1, 2: begin
          if (len > 192 || len > int'(inBytes)) begin
            tag = "R5"; eBab = 1; eAct = 0;
          end else begin
            tag = (rspKind == 3'd2) ? "R4" : "R3";
            eBytes = int'(inBytes) - len;
            sum = int'(inOffset) + len;
            eOff = sum % 4096;
            if (sum > 4095) ePage = 1;
            eWr = (len != 0) ? 1 : 0;
            if (rspKind != 3'd2) eAct = 0;
          end
        end
        4: begin tag = "R6"; eErr = 1; eAct = 0; end
        5: begin
          tag = "R7"; eX = 1;
          if (cnt < 2 && !uframeEnd) begin eRetry = 1; refCnt = cnt + 1; end
          else eAct = 0;
        end
        3: begin tag = "R9"; if (lastCs) eAct = 0; end
        default: tag = "R9";
      endcase
    end else begin
      refCnt = cnt;
    end
    if (forceTag != "") tag = forceTag;
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic setDesc(int b, int o, int p, int a);
    inBytes = 10'(b); inOffset = 12'(o); inPage = p[0]; inActive = a[0];
    inErr = 1'b0; inBabble = 1'b0; inXact = 1'b0;
    inMask = 8'h01; uframeBit = 8'h04;
  endtask

  task automatic rsp(int kind, int len, bit last, bit ufe, bit nd, string tag);
    rspValid = 1'b1; rspKind = 3'(kind); rxLen = 11'(len);
    lastCs = last; uframeEnd = ufe; newDesc = nd;
    cycle(tag);
    rspValid = 1'b0; newDesc = 1'b0; lastCs = 1'b0; uframeEnd = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state: all outputs zero
    compareAll("R1");
    rstN = 1'b1;
    cycle("R1");

    // R3 plain data, then a page carry, then zero length
    setDesc(300, 10, 0, 1);     rsp(0, 100, 0, 0, 1, "R3");
    setDesc(400, 4000, 0, 1);   rsp(1, 150, 0, 0, 0, "R3");
    setDesc(0, 55, 1, 1);       rsp(0, 0, 0, 0, 0, "R3");
    // R4 MDATA keeps Active, maximum payload
    setDesc(500, 20, 0, 1);     rsp(2, 192, 0, 0, 0, "R4");
    // R5 babble: zero remaining, overrun, over 192
    setDesc(0, 77, 0, 1);       rsp(1, 10, 0, 0, 0, "R5");
    setDesc(50, 77, 0, 1);      rsp(0, 51, 0, 0, 0, "R5");
    setDesc(900, 77, 0, 1);     rsp(2, 193, 0, 0, 0, "R5");
    // R6 error
    setDesc(100, 5, 0, 1);      rsp(4, 0, 0, 0, 0, "R6");
    // R7 two retries then stop
    setDesc(100, 5, 0, 1);
    rsp(5, 0, 0, 0, 1, "R7"); rsp(5, 0, 0, 0, 0, "R7"); rsp(5, 0, 0, 0, 0, "R7");
    // R7 micro-frame end blocks retry
    rsp(5, 0, 0, 1, 0, "R7");
    // R8 cleared by other response
    rsp(5, 0, 0, 0, 0, "R8"); rsp(5, 0, 0, 0, 0, "R8");
    rsp(3, 0, 0, 0, 0, "R8"); rsp(5, 0, 0, 0, 0, "R8");
    // R8 newDesc in the same cycle as an error with count used up
    rsp(5, 0, 0, 0, 0, "R8"); rsp(5, 0, 0, 0, 1, "R8");
    // R9 NYET last / not last / unused code
    setDesc(60, 9, 1, 1);       rsp(3, 40, 1, 0, 0, "R9");
    rsp(3, 40, 0, 0, 0, "R9");  rsp(6, 40, 1, 0, 0, "R9"); rsp(7, 3, 0, 0, 0, "R9");
    // R1 idle cycles hold
    cycle("R1"); cycle("R1");

    for (int i = 0; i < 3000; i++) begin
      int sel;
      inBytes = 10'($urandom); inOffset = 12'($urandom);
      if ($urandom % 4 == 0) inOffset = 12'(4096 - ($urandom % 200));
      inPage = 1'($urandom); inActive = 1'($urandom); inErr = 1'($urandom);
      inBabble = 1'($urandom); inXact = 1'($urandom);
      inMask = 8'($urandom); uframeBit = 8'(1 << ($urandom % 8));
      sel = int'($urandom % 4);
      rxLen = (sel == 0) ? 11'($urandom) : 11'($urandom % 200);
      if (sel == 1) inBytes = 10'($urandom % 8);
      rspKind = ($urandom % 3 == 0) ? 3'd5 : 3'($urandom);
      lastCs = 1'($urandom); uframeEnd = ($urandom % 6 == 0);
      newDesc = ($urandom % 8 == 0); rspValid = ($urandom % 5 != 0);
      cycle("");
    end
    rspValid = 1'b0; newDesc = 1'b0;
    cycle("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule